// File: doc/BRIEF.md
# Bus Access Trace Serializer

This block sits beside a shared memory-mapped bus that several masters use, and it never drives that bus. In every cycle where an access is acknowledged, it builds one trace record from the address, the write-enable bit, the four byte-select bits and the number of the master that received the acknowledge. It then stores the record in a small FIFO.

A slicer takes records out of the FIFO and extends each one with zero bits up to a whole number of 32-bit words. The padding rule always adds at least one zero bit. The slicer sends the words on a valid/ready stream, starting with the lowest word. The number of padding bits is a constant output, so a decoder can strip the padding. If the FIFO is full when a new access completes, that access is discarded and a sticky overflow flag is raised. Software clears the flag with a pulse on a clear input.

Top module: `bus_trace_serializer`

## Requirements
- R1: A record is captured only in a cycle where at least one bit of `bus_ack_i` is high. The master number stored in the record is the position of the lowest set bit of `bus_ack_i`.
- R2: Record bit layout, starting from bit 0:
  - address in bits [ADDR_W-1:0];
  - write enable at bit ADDR_W;
  - byte selects in bits [ADDR_W+4:ADDR_W+1];
  - master number in the next clog2(N_MST) bits;
  - all remaining bits are zero.
- R3: A record of N bits is padded with zeros to N + (32 − (N mod 32)) bits. `pad_bits_o` reports the padding count. With the default parameters, N = 39, padding = 25 and there are 2 words per record.
- R4: The words of a record are sent lowest word first, and each word is one accepted beat. The next record's first word can follow the last accepted word in the very next cycle.
- R5: While `src_valid_o` is high and `src_ready_i` is low, `src_valid_o` stays high and `src_data_o` stays unchanged.
- R6: Up to FIFO_DEPTH records waiting in the FIFO are held without loss while the stream is stalled. A record needs two clock edges after its acknowledge to reach the output.
- R7: A capture that arrives while the FIFO holds FIFO_DEPTH records is discarded and sets `ovf_o`. The flag stays set until `ovf_clr_i` is pulsed. If a discard and a clear happen in the same cycle, the flag stays set.
- R8: While `rst_ni` is low, the FIFO is empty, the slicer is idle, `src_valid_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_adr_i | input | ADDR_W | Observed bus address |
| bus_we_i | input | 1 | Observed write enable |
| bus_sel_i | input | 4 | Observed byte selects |
| bus_ack_i | input | N_MST | Acknowledge, one bit per master |
| src_valid_o | output | 1 | Stream word valid |
| src_ready_i | input | 1 | Stream word accepted |
| src_data_o | output | 32 | Stream word |
| pad_bits_o | output | 6 | Number of zero padding bits per record |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |

## Verification
Two events can fall in the same cycle:
- an acknowledge that the full FIFO must discard;
- a software clear of the overflow flag.

To provoke this, the bench stalls the stream until the FIFO fills, then pulses `ovf_clr_i` in cycles that also carry an acknowledge. A FIFO pop and a push also coincide during the drain, and on the last word of a record the next record is loaded in the same cycle. A behavioural queue model judges every cycle: it expects the flag to stay set, the full-FIFO capture to be dropped even when a pop happens in that cycle, and no beat to be lost or repeated.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int unsigned WORD_W = 32;

  // Padding rule: always at least one zero bit, whole word when already aligned
  function automatic int unsigned pad_of(int unsigned n);
    return WORD_W - (n % WORD_W);
  endfunction

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bts_capture.sv
module bts_capture import bts_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_MST  = 4,
  parameter int unsigned ENT_W  = 64
) (
  input  logic [ADDR_W-1:0] adr_i,
  input  logic              we_i,
  input  logic [3:0]        sel_i,
  input  logic [N_MST-1:0]  ack_i,
  output logic              cap_o,
  output logic [ENT_W-1:0]  rec_o
);
  localparam int unsigned MIDX_W = idx_w(N_MST);
  localparam int unsigned REC_W  = ADDR_W + 5 + MIDX_W;

  logic [MIDX_W-1:0] midx;

  // Lowest acknowledged master wins
  always_comb begin
    midx = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (ack_i[i]) midx = MIDX_W'(i);
    end
  end

  assign cap_o = |ack_i;

  always_comb begin
    rec_o = '0;
    rec_o[REC_W-1:0] = {midx, sel_i, we_i, adr_i};
  end
endmodule

// File: rtl/bts_fifo.sv
module bts_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/bts_slicer.sv
module bts_slicer import bts_pkg::*; #(
  parameter int unsigned ENT_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ENT_W-1:0]  rec_i,
  input  logic              rec_vld_i,
  output logic              pop_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned N_WORDS = ENT_W / WORD_W;
  localparam int unsigned IDX_W   = idx_w(N_WORDS);

  logic [ENT_W-1:0]  cur_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, last;
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = cur_q[w*WORD_W +: WORD_W];
  end

  assign last    = (idx_q == IDX_W'(N_WORDS - 1));
  assign pop_o   = rec_vld_i && (!busy_q || (ready_i && last));
  assign valid_o = busy_q;
  assign data_o  = words[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cur_q  <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cur_q  <= rec_i;
    end else if (busy_q && ready_i) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_trace_serializer.sv
module bus_trace_serializer import bts_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned N_MST      = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_adr_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_sel_i,
  input  logic [N_MST-1:0]  bus_ack_i,
  output logic              src_valid_o,
  input  logic              src_ready_i,
  output logic [31:0]       src_data_o,
  output logic [5:0]        pad_bits_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  localparam int unsigned MIDX_W = idx_w(N_MST);
  localparam int unsigned REC_W  = ADDR_W + 5 + MIDX_W;
  localparam int unsigned PAD_N  = pad_of(REC_W);
  localparam int unsigned ENT_W  = REC_W + PAD_N;
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);

  logic             cap, full, empty, pop;
  logic [ENT_W-1:0] cap_rec, head_rec;
  logic [CNT_W-1:0] fifo_cnt;
  logic             ovf_q;

  bts_capture #(.ADDR_W(ADDR_W), .N_MST(N_MST), .ENT_W(ENT_W)) u_cap (
    .adr_i(bus_adr_i), .we_i(bus_we_i), .sel_i(bus_sel_i), .ack_i(bus_ack_i),
    .cap_o(cap), .rec_o(cap_rec)
  );

  bts_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(cap), .din_i(cap_rec), .full_o(full),
    .pop_i(pop), .dout_o(head_rec), .empty_o(empty), .cnt_o(fifo_cnt)
  );

  bts_slicer #(.ENT_W(ENT_W)) u_slc (
    .clk_i, .rst_ni,
    .rec_i(head_rec), .rec_vld_i(!empty), .pop_o(pop),
    .valid_o(src_valid_o), .ready_i(src_ready_i), .data_o(src_data_o)
  );

  // Drop wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ovf_q <= 1'b0;
    else if (cap && full)  ovf_q <= 1'b1;
    else if (ovf_clr_i)    ovf_q <= 1'b0;
  end

  assign ovf_o      = ovf_q;
  assign pad_bits_o = 6'(PAD_N);
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int unsigned N_MST      = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] bus_ack_i,
  input logic             src_valid_o,
  input logic             src_ready_i,
  input logic [31:0]      src_data_o,
  input logic             ovf_o,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] fifo_cnt
);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o && !src_ready_i |=> src_valid_o && $stable(src_data_o));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !(|bus_ack_i) |=> !ovf_o);

  a_r1_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(|bus_ack_i));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|bus_ack_i) |=> fifo_cnt <= $past(fifo_cnt));
endmodule

bind bus_trace_serializer bts_checker #(
  .N_MST(N_MST), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .bus_ack_i, .src_valid_o, .src_ready_i, .src_data_o,
  .ovf_o, .ovf_clr_i, .fifo_cnt
);

// File: tb/bus_trace_serializer_bench.sv
`timescale 1ns/1ps
module bus_trace_serializer_bench;
  localparam int DEPTH = 4;
  localparam int NW    = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] adr = '0;
  logic        we = 1'b0;
  logic [3:0]  sel = '0;
  logic [3:0]  ack = '0;
  logic        ready = 1'b0;
  logic        clr = 1'b0;
  logic        valid, ovf;
  logic [31:0] data;
  logic [5:0]  pad;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_trace_serializer u_bus_trace_serializer (
    .clk_i(clk), .rst_ni, .bus_adr_i(adr), .bus_we_i(we), .bus_sel_i(sel),
    .bus_ack_i(ack), .src_valid_o(valid), .src_ready_i(ready),
    .src_data_o(data), .pad_bits_o(pad), .ovf_o(ovf), .ovf_clr_i(clr)
  );

  // Reference model
  logic [63:0] q[$];
  logic [63:0] m_cur;
  bit          m_busy, m_ovf;
  int          m_idx;

  function automatic logic [63:0] mk_rec(logic [31:0] a, logic w, logic [3:0] s, logic [3:0] k);
    logic [1:0] mi = '0;
    for (int i = 0; i < 4; i++) if (k[i]) begin mi = 2'(i); break; end
    mk_rec = 64'(0);
    mk_rec[31:0]  = a;          // R2 layout
    mk_rec[32]    = w;
    mk_rec[36:33] = s;
    mk_rec[38:37] = mi;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); m_busy = 0; m_idx = 0; m_ovf = 0; m_cur = '0;
    end else begin
      bit full_old, pop;
      full_old = (q.size() == DEPTH);
      pop = (q.size() > 0) && (!m_busy || (ready && m_idx == NW - 1));
      if (m_busy && ready) begin
        if (m_idx == NW - 1) m_busy = 0; else m_idx++;
      end
      if (pop) begin m_cur = q.pop_front(); m_busy = 1; m_idx = 0; end
      if (ack != 0) begin
        if (full_old) m_ovf = 1;
        else q.push_back(mk_rec(adr, we, sel, ack));
      end
      if (clr && !(ack != 0 && full_old)) m_ovf = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(valid === m_busy, "R4 R6 R8 valid", 64'(valid), 64'(m_busy));
      if (m_busy) chk(data === m_cur[m_idx*32 +: 32], "R2 R4 R5 data", 64'(data), 64'(m_cur[m_idx*32 +: 32]));
      chk(ovf === m_ovf, "R7 R8 ovf", 64'(ovf), 64'(m_ovf));
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic cyc(logic [3:0] k, logic r, logic c);
    @(negedge clk);
    #0.5;
    lfsr = step(lfsr);
    adr = {lfsr, step(lfsr)};
    we = lfsr[3]; sel = lfsr[7:4];
    ack = k; ready = r; clr = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(valid === 1'b0 && ovf === 1'b0, "R8 reset outputs", {valid, ovf}, 0);
    chk(pad === 6'd25, "R3 pad bits", 64'(pad), 25);
    rst_ni = 1'b1;
    // R1: traffic with no acknowledge yields nothing
    for (int i = 0; i < 6; i++) cyc(4'b0000, 1'b1, 1'b0);
    // R1 R2: each master, plus several acks at once
    cyc(4'b0001, 1, 0); cyc(4'b0010, 1, 0); cyc(4'b1000, 1, 0);
    cyc(4'b0110, 1, 0); cyc(4'b1100, 1, 0); cyc(4'b0000, 1, 0);
    for (int i = 0; i < 10; i++) cyc(4'b0000, 1'b1, 1'b0);
    // R6: fill exactly DEPTH+1 (one in slicer) while stalled, no loss
    for (int i = 0; i < DEPTH + 1; i++) cyc(4'b0100, 1'b0, 1'b0);
    cyc(4'b0000, 1'b0, 1'b0);
    chk(ovf === 1'b0, "R6 no drop at depth", 64'(ovf), 0);
    // R7: overflow, clear coinciding with drops
    cyc(4'b0001, 1'b0, 1'b0);
    cyc(4'b0010, 1'b0, 1'b1);
    cyc(4'b0000, 1'b0, 1'b0);
    chk(ovf === 1'b1, "R7 set wins over clear", 64'(ovf), 1);
    cyc(4'b0000, 1'b0, 1'b1);
    cyc(4'b0000, 1'b0, 1'b0);
    chk(ovf === 1'b0, "R7 clear", 64'(ovf), 0);
    // R4 R5 R7: random ready and acks, occasional clears
    for (int i = 0; i < 400; i++) begin
      cyc((lfsr[9:8] == 0) ? lfsr[13:10] : 4'b0000, lfsr[1] | lfsr[2], lfsr[11:5] == 0);
    end
    for (int i = 0; i < 40; i++) cyc(4'b0000, 1'b1, 1'b1);
    // R8: reset with records pending
    for (int i = 0; i < 3; i++) cyc(4'b1000, 1'b0, 1'b0);
    @(negedge clk); #0.5; rst_ni = 1'b0; ack = '0;
    #1;
    chk(valid === 1'b0 && ovf === 1'b0, "R8 mid reset", {valid, ovf}, 0);
    @(negedge clk); #0.5; rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) cyc(4'b0000, 1'b1, 1'b0);
    chk(valid === 1'b0, "R8 fifo emptied", 64'(valid), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule